// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This block takes one single-precision floating-point operand and a three-bit rounding-mode code, and returns the integral value nearest to the operand under that mode. The result stays in single-precision format; it is not converted to an integer. The block computes the result in one combinational path. A parameter selects whether a single register stage sits on the output.

The only flag it reports is invalid, and only a signalling NaN raises it. Zeros, infinities and operands that are already integral because of their exponent leave the block bit-for-bit unchanged. Every NaN comes out as the canonical quiet NaN. Inexactness is never signalled. A negative operand that rounds to zero yields negative zero.

Top module: `fround_unit`

## Requirements
- R1: Inputs of +0 (0x00000000), -0 (0x80000000), +inf (0x7F800000) and -inf (0xFF800000) are returned bit-identical, with invalid low, in every rounding mode.
- R2: A signalling NaN (exponent field all ones, fraction nonzero, fraction bit 22 clear) returns 0x7FC00000 with invalid high.
- R3: A quiet NaN (exponent all ones, fraction bit 22 set) returns 0x7FC00000 with invalid low.
- R4: A finite operand whose biased exponent field (bits 30:23) is 150 or more is returned unchanged.
- R5: Mode code 0 rounds to nearest and breaks ties to the even integer (2.5 gives 2.0, 3.5 gives 4.0).
- R6: Mode code 1 rounds toward zero (-1.7 gives -1.0).
- R7: Mode code 2 rounds toward minus infinity and mode code 3 rounds toward plus infinity (1.25 gives 1.0 and 2.0 respectively; -1.25 in code 2 gives -2.0).
- R8: Mode code 4 rounds to nearest and breaks ties away from zero (2.5 gives 3.0, -2.5 gives -3.0).
- R9: Mode codes 5, 6 and 7 behave exactly like code 0.
- R10: An operand of magnitude below 1, including subnormals, gives a signed zero or a signed one. The operand's sign is kept, so a negative operand that rounds to zero gives 0x80000000.
- R11: A rounding increment that carries out of the fraction raises the exponent correctly (1.5 gives 2.0 in code 0; 8388607.5 gives 8388608.0).
- R12: For every non-NaN operand the result has the operand's sign, is integral, and invalid stays low.
- R13: With the output register enabled, out_valid, the result and invalid appear one clock after in_valid is sampled. Reset drives out_valid, the result and invalid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| op_a | input | 32 | Single-precision operand |
| rnd_mode | input | 3 | Rounding mode code (0 to 4; 5 to 7 treated as 0) |
| out_valid | output | 1 | Result valid |
| res | output | 32 | Integral result in single-precision format |
| invalid | output | 1 | Invalid-operation flag (signalling NaN only) |

## Verification
The bench builds the unit with the default 8-bit exponent, 23-bit fraction and the output register enabled. With these values the fixed one-cycle latency, the reset values and the drop of out_valid can all be observed. The single-precision width lets the bench model the result as exact double arithmetic on the decoded operand. Random exponents are concentrated around the binary point, between 2^-17 and 2^32. This covers the fraction-clearing path, the carry into the exponent, the below-one path and the already-integral pass-through, and random codes cover all eight mode values.

// File: rtl/fr_pkg.sv
package fr_pkg;
   // rounding mode codes; codes above 4 are folded onto nearest-even
   typedef enum logic [2:0] {
      RM_NEAR_EVEN = 3'd0,
      RM_TO_ZERO   = 3'd1,
      RM_DOWN      = 3'd2,
      RM_UP        = 3'd3,
      RM_NEAR_MAX  = 3'd4
   } fr_mode_e;

   // operand classes seen by the datapath
   typedef enum logic [2:0] {
      CL_ZERO,
      CL_INF,
      CL_QNAN,
      CL_SNAN,
      CL_BIG,    // already integral by exponent
      CL_SMALL,  // nonzero magnitude below one
      CL_MID     // needs fraction bits cleared
   } fr_class_e;

   function automatic fr_mode_e fr_decode_mode(input logic [2:0] code);
      case (code)
         3'd1:    return RM_TO_ZERO;
         3'd2:    return RM_DOWN;
         3'd3:    return RM_UP;
         3'd4:    return RM_NEAR_MAX;
         default: return RM_NEAR_EVEN;
      endcase
   endfunction
endpackage

// File: rtl/fr_classify.sv
module fr_classify
   import fr_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   output fr_class_e            cls
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
   localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] EXP_INTG = EXP_W'(BIAS + MAN_W);

   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] mn;

   assign ex = op[EXP_W+MAN_W-1:MAN_W];
   assign mn = op[MAN_W-1:0];

   always_comb begin
      if (ex == EXP_ONES) begin
         if (mn == '0)          cls = CL_INF;
         else if (mn[MAN_W-1])  cls = CL_QNAN;
         else                   cls = CL_SNAN;
      end else if (ex == '0 && mn == '0) begin
         cls = CL_ZERO;
      end else if (ex >= EXP_INTG) begin
         cls = CL_BIG;
      end else if (ex < EXP_ONE) begin
         cls = CL_SMALL;
      end else begin
         cls = CL_MID;
      end
   end
endmodule

// File: rtl/fr_round_core.sv
module fr_round_core
   import fr_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   input  logic [2:0]           mode_code,
   input  fr_class_e            cls,
   output logic [EXP_W+MAN_W:0] rounded
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int MW1  = MAN_W + 1;
   localparam int MAG_W = EXP_W + MAN_W;
   localparam int SH_W = $clog2(MAN_W + 1);
   localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
   localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);

   fr_mode_e          mode;
   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [MAN_W-1:0]  mn;
   logic [MAN_W:0]    sig;
   int                fb;
   logic [SH_W-1:0]   sh;
   logic [MAN_W:0]    mask;
   logic [MAN_W:0]    half;
   logic [MAN_W:0]    fracv;
   logic              lsb;
   logic              up_mid;
   logic              up_small;
   logic              gt_half;
   logic              eq_half;
   logic [MAG_W-1:0]  ext_mask;
   logic [MAG_W-1:0]  mag_mid;
   logic [EXP_W+MAN_W:0] res_small;

   assign mode = fr_decode_mode(mode_code);
   assign {sgn, ex, mn} = op;
   assign sig = {1'b1, mn};

   // fraction bit count for the mid range, clamped so other classes stay legal
   always_comb begin
      fb = BIAS + MAN_W - int'(ex);
      if (fb < 1)     fb = 1;
      if (fb > MAN_W) fb = MAN_W;
      sh = fb[SH_W-1:0];
   end

   always_comb begin
      mask  = (MW1'(1) << sh) - MW1'(1);
      half  = MW1'(1) << (sh - SH_W'(1));
      fracv = sig & mask;
      lsb   = sig[sh];
      case (mode)
         RM_NEAR_EVEN: up_mid = (fracv > half) || (fracv == half && lsb);
         RM_NEAR_MAX:  up_mid = (fracv >= half);
         RM_UP:        up_mid = !sgn && (fracv != '0);
         RM_DOWN:      up_mid = sgn && (fracv != '0);
         default:      up_mid = 1'b0;
      endcase
      ext_mask = {{EXP_W{1'b0}}, mask[MAN_W-1:0]};
      // a carry out of the fraction field lands in the exponent by itself
      mag_mid  = ({ex, mn} & ~ext_mask) + (up_mid ? ext_mask + MAG_W'(1) : '0);
   end

   // magnitude below one: result is zero or one with the operand's sign
   always_comb begin
      gt_half = (ex == EXP_HALF) && (mn != '0);
      eq_half = (ex == EXP_HALF) && (mn == '0);
      case (mode)
         RM_NEAR_EVEN: up_small = gt_half;
         RM_NEAR_MAX:  up_small = gt_half || eq_half;
         RM_UP:        up_small = !sgn;
         RM_DOWN:      up_small = sgn;
         default:      up_small = 1'b0;
      endcase
      res_small = {sgn, (up_small ? EXP_ONE : {EXP_W{1'b0}}), {MAN_W{1'b0}}};
   end

   assign rounded = (cls == CL_SMALL) ? res_small : {sgn, mag_mid};
endmodule

// File: rtl/fr_out_stage.sv
module fr_out_stage #(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   input  logic         f_in,
   output logic         v_out,
   output logic [W-1:0] d_out,
   output logic         f_out
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_out <= 1'b0;
               d_out <= '0;
               f_out <= 1'b0;
            end else begin
               v_out <= v_in;
               d_out <= d_in;
               f_out <= f_in & v_in;
            end
         end
      end else begin : g_comb
         assign v_out = v_in;
         assign d_out = d_in;
         assign f_out = f_in & v_in;
      end
   endgenerate
endmodule

// File: rtl/fround_unit.sv
module fround_unit
   import fr_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter bit REG_OUT = 1'b1,
   localparam int W      = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] op_a,
   input  logic [2:0]   rnd_mode,
   output logic         out_valid,
   output logic [W-1:0] res,
   output logic         invalid
);
   localparam logic [W-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   initial begin
      if (EXP_W < 3)       $fatal(1, "fround_unit: EXP_W too small");
      if (MAN_W < 2)       $fatal(1, "fround_unit: MAN_W too small");
      if (MAN_W + 2 >= (1 << (EXP_W - 1)))
                           $fatal(1, "fround_unit: exponent range too narrow");
   end

   fr_class_e    cls;
   logic [W-1:0] core_res;
   logic [W-1:0] sel_res;
   logic         sel_inv;

   fr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (op_a),
      .cls (cls)
   );

   fr_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
      .op        (op_a),
      .mode_code (rnd_mode),
      .cls       (cls),
      .rounded   (core_res)
   );

   always_comb begin
      sel_inv = 1'b0;
      case (cls)
         CL_ZERO, CL_INF, CL_BIG: sel_res = op_a;
         CL_QNAN:                 sel_res = CANON_NAN;
         CL_SNAN: begin
            sel_res = CANON_NAN;
            sel_inv = 1'b1;
         end
         default:                 sel_res = core_res;
      endcase
   end

   fr_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (in_valid),
      .d_in  (sel_res),
      .f_in  (sel_inv),
      .v_out (out_valid),
      .d_out (res),
      .f_out (invalid)
   );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter bit REG_OUT = 1'b1,
   localparam int W      = 1 + EXP_W + MAN_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [W-1:0] op_a,
   input logic [2:0]   rnd_mode,
   input logic         out_valid,
   input logic [W-1:0] res,
   input logic         invalid
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
   localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] EXP_INTG = EXP_W'(BIAS + MAN_W);
   localparam logic [W-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic         src_v;
   logic [W-1:0] src_a;
   logic [2:0]   src_m;

   generate
      if (REG_OUT) begin : g_lag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_v <= 1'b0;
               src_a <= '0;
               src_m <= '0;
            end else begin
               src_v <= in_valid;
               src_a <= op_a;
               src_m <= rnd_mode;
            end
         end
      end else begin : g_now
         assign src_v = in_valid;
         assign src_a = op_a;
         assign src_m = rnd_mode;
      end
   endgenerate

   logic [EXP_W-1:0] s_ex, r_ex;
   logic [MAN_W-1:0] s_mn, r_mn;
   logic             s_nan, s_snan, s_zinf, r_frac_clear;
   int               r_fb;

   assign s_ex   = src_a[W-2:MAN_W];
   assign s_mn   = src_a[MAN_W-1:0];
   assign r_ex   = res[W-2:MAN_W];
   assign r_mn   = res[MAN_W-1:0];
   assign s_nan  = (s_ex == EXP_ONES) && (s_mn != '0);
   assign s_snan = s_nan && !s_mn[MAN_W-1];
   assign s_zinf = (s_ex == EXP_ONES && s_mn == '0) || (s_ex == '0 && s_mn == '0);

   always_comb begin
      r_fb = BIAS + MAN_W - int'(r_ex);
      if (r_ex >= EXP_INTG)     r_frac_clear = 1'b1;
      else if (r_ex < EXP_ONE)  r_frac_clear = (r_ex == '0) && (r_mn == '0);
      else                      r_frac_clear = ((r_mn & MAN_W'((1 << r_fb) - 1)) == '0);
   end

   assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == src_v);

   assert_zero_inf_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && s_zinf) |-> (res == src_a && !invalid));

   assert_snan_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && s_snan) |-> (invalid && res == CANON_NAN));

   assert_qnan_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && s_nan && !s_snan) |-> (!invalid && res == CANON_NAN));

   assert_no_stray_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && invalid) |-> s_snan);

   assert_integral_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !s_nan) |-> (r_frac_clear && res[W-1] == src_a[W-1]));

   assert_big_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !s_nan && s_ex >= EXP_INTG) |-> res == src_a);

   assert_trunc_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !s_nan && src_m == 3'd1) |-> (res[W-2:0] <= src_a[W-2:0]));
endmodule

bind fround_unit fr_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .rnd_mode  (rnd_mode),
   .out_valid (out_valid),
   .res       (res),
   .invalid   (invalid)
);

// File: tb/sim_fround_unit.sv
module sim_fround_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int N_RANDOM   = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [2:0]  rnd_mode = '0;
   logic        out_valid;
   logic [31:0] res;
   logic        invalid;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fround_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_a      (op_a),
      .rnd_mode  (rnd_mode),
      .out_valid (out_valid),
      .res       (res),
      .invalid   (invalid)
   );

   // reference result from exact real arithmetic on the decoded operand
   function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [2:0] m);
      logic       s;
      int         e;
      int         f;
      real        mag, fl, fr;
      int         n;
      int         p;
      bit         up;
      logic [2:0] mm;
      s = a[31];
      e = int'(a[30:23]);
      f = int'(a[22:0]);
      if (e == 255) return (f == 0) ? a : 32'h7FC00000;
      if (e == 0 && f == 0) return a;
      if (e >= 150) return a;
      mm  = (m > 3'd4) ? 3'd0 : m;
      mag = ((e == 0) ? real'(f) : real'(f) + 8388608.0) * (2.0 ** real'(((e == 0) ? 1 : e) - 150));
      fl  = $floor(mag);
      fr  = mag - fl;
      n   = $rtoi(fl);
      case (mm)
         3'd0:    up = (fr > 0.5) || (fr == 0.5 && (n % 2 == 1));
         3'd2:    up = s && (fr > 0.0);
         3'd3:    up = !s && (fr > 0.0);
         3'd4:    up = (fr >= 0.5);
         default: up = 1'b0;
      endcase
      if (up) n = n + 1;
      if (n == 0) return {s, 31'b0};
      p = 0;
      for (int k = 0; k < 31; k++) if (n >= (1 << k)) p = k;
      return {s, 8'(127 + p), 23'((n << (23 - p)) & 32'h007FFFFF)};
   endfunction

   function automatic logic ref_inv(input logic [31:0] a);
      return (a[30:23] == 8'hFF) && (a[22:0] != '0) && !a[22];
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // drive at a falling edge, sample after the capturing rising edge
   task automatic apply(input string tag, input logic [31:0] a, input logic [2:0] m,
                        input logic [31:0] exp_r, input logic exp_i);
      @(negedge clk);
      in_valid = 1'b1;
      op_a     = a;
      rnd_mode = m;
      @(negedge clk);
      chk({tag, " result"}, res, exp_r);
      chk({tag, " invalid"}, {31'b0, invalid}, {31'b0, exp_i});
      chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
   endtask

   task automatic directed(input string tag, input logic [31:0] a, input logic [2:0] m,
                           input logic [31:0] exp_r);
      apply(tag, a, m, exp_r, ref_inv(a));
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20250713);

      // R13: reset state
      repeat (3) @(negedge clk);
      chk("R13 reset valid", {31'b0, out_valid}, 32'd0);
      chk("R13 reset result", res, 32'd0);
      chk("R13 reset invalid", {31'b0, invalid}, 32'd0);
      rst_n = 1'b1;

      // R1: zeros and infinities unchanged
      directed("R1 +0", 32'h00000000, 3'd0, 32'h00000000);
      directed("R1 -0", 32'h80000000, 3'd3, 32'h80000000);
      directed("R1 +inf", 32'h7F800000, 3'd2, 32'h7F800000);
      directed("R1 -inf", 32'hFF800000, 3'd4, 32'hFF800000);
      // R2: signalling NaN
      apply("R2 snan", 32'h7F800001, 3'd0, 32'h7FC00000, 1'b1);
      apply("R2 neg snan", 32'hFFA00000, 3'd1, 32'h7FC00000, 1'b1);
      // R3: quiet NaN
      apply("R3 qnan", 32'hFFC12345, 3'd3, 32'h7FC00000, 1'b0);
      // R4: already integral
      directed("R4 2^23+1", 32'h4B000001, 3'd3, 32'h4B000001);
      directed("R4 max finite", 32'h7F7FFFFF, 3'd2, 32'h7F7FFFFF);
      // R5: nearest even
      directed("R5 2.5", 32'h40200000, 3'd0, 32'h40000000);
      directed("R5 3.5", 32'h40600000, 3'd0, 32'h40800000);
      // R6: toward zero
      directed("R6 -1.7", 32'hBFD9999A, 3'd1, 32'hBF800000);
      // R7: directed modes
      directed("R7 1.25 up", 32'h3FA00000, 3'd3, 32'h40000000);
      directed("R7 1.25 down", 32'h3FA00000, 3'd2, 32'h3F800000);
      directed("R7 -1.25 down", 32'hBFA00000, 3'd2, 32'hC0000000);
      // R8: nearest, ties away
      directed("R8 2.5", 32'h40200000, 3'd4, 32'h40400000);
      directed("R8 -2.5", 32'hC0200000, 3'd4, 32'hC0400000);
      // R9: reserved codes act as nearest even
      directed("R9 code5", 32'h40200000, 3'd5, 32'h40000000);
      directed("R9 code7", 32'h40600000, 3'd7, 32'h40800000);
      // R10: magnitude below one
      directed("R10 -0.3", 32'hBE99999A, 3'd0, 32'h80000000);
      directed("R10 0.5 even", 32'h3F000000, 3'd0, 32'h00000000);
      directed("R10 0.5 away", 32'h3F000000, 3'd4, 32'h3F800000);
      directed("R10 -0.25 down", 32'hBE800000, 3'd2, 32'hBF800000);
      directed("R10 0.25 up", 32'h3E800000, 3'd3, 32'h3F800000);
      directed("R10 +sub up", 32'h00000001, 3'd3, 32'h3F800000);
      directed("R10 -sub up", 32'h80000001, 3'd3, 32'h80000000);
      // R11: carry into the exponent
      directed("R11 1.5", 32'h3FC00000, 3'd0, 32'h40000000);
      directed("R11 8388607.5", 32'h4AFFFFFF, 3'd0, 32'h4B000000);

      // R13: out_valid follows in_valid after one clock
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R13 valid drop", {31'b0, out_valid}, 32'd0);
      chk("R13 no flag when idle", {31'b0, invalid}, 32'd0);

      // R12 with R5..R10: random operands against the reference
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [31:0] a;
         logic [2:0]  m;
         int          sel;
         int          ex;
         sel = int'($urandom % 16);
         if (sel == 0)      ex = 0;
         else if (sel == 1) ex = 255;
         else               ex = 110 + int'($urandom % 50);
         a = {1'($urandom), 8'(ex), 23'($urandom)};
         if (sel == 2) a[22:0] = 23'($urandom % 4) << 20;
         m = 3'($urandom);
         apply("R12 random", a, m, ref_res(a, m), ref_inv(a));
      end

      @(negedge clk);
      in_valid = 1'b0;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule